// File: doc/BRIEF.md
# Workload-Based Temperature Predictor

This block gives a processing element an estimate of its own thermal state without reading a sensor. It counts work. Each cycle, a grant issued to one of the four neighbouring elements raises an 8-bit temperature estimate, and so does a packet accepted from the element's local input stream. The larger the workload, the hotter the estimate.

A watchdog-style idle timer sets the window over which the prediction is made. Any activity restarts the window. When a whole window passes with no activity, the estimate cools by a fixed step and the timer goes back to its initial value. The estimate never cools below an ambient floor.

A registered flag reports when the estimate lies above a threshold of 90. Migration logic elsewhere in the element can use that flag to stop taking work.

Top module: `thermal_load_estimator`

## Requirements
- R1: While reset is asserted, and after it is released, the estimate equals the ambient floor FLOOR (default 26), the over-threshold flag is 0 and the idle window starts empty.
- R2: In every cycle, each active event source adds STEP_UP (default 4) to the estimate. The sources are the four grant bits (bit 0 north, bit 1 east, bit 2 west, bit 3 south) and the local accept strobe. When k sources are active in the same cycle, the estimate rises by k×STEP_UP.
- R3: The estimate saturates at 255 and never wraps.
- R4: A cycle with any active source restarts the idle window, and that cycle does not cool the estimate.
- R5: After WINDOW (default 16) consecutive idle cycles, the estimate falls by COOL_STEP (default 2) on the WINDOW-th idle clock edge, and a new window begins. Before that edge the estimate holds.
- R6: Cooling never takes the estimate below FLOOR. Idle time spent at the floor leaves it at the floor.
- R7: The over-threshold flag is 1 exactly when the estimate held in the previous cycle was strictly greater than HOT_LIMIT (default 90). It lags the estimate by one cycle, and an estimate of exactly 90 gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| nbr_grant | input | 4 | Grants issued to neighbours: bit 0 north, 1 east, 2 west, 3 south |
| local_accept | input | 1 | Strobe: one packet accepted from the local stream this cycle |
| est_temp | output | 8 | Predicted temperature |
| over_limit | output | 1 | Registered flag: previous estimate above HOT_LIMIT |

## Verification
The bench raises the estimate one source at a time and then with all five sources at once. A design that counted only one event per cycle would show a rise of 4 where 20 is expected. The bench samples the estimate after 15 and after 16 idle cycles, and also inserts a single event partway through a window. A timer that was off by one, or that was not restarted by activity, would cool one cycle early or late. The bench drives the estimate to exactly 90 and then to 94, to catch a comparison that uses greater-or-equal or a flag that is not delayed by a cycle. It also pushes the estimate past 255 and idles it at the floor, which exposes wrap-around and underflow.

// File: rtl/thermal_load_estimator.sv
module thermal_load_estimator #(
  parameter int EST_W     = 8,
  parameter int STEP_UP   = 4,
  parameter int COOL_STEP = 2,
  parameter int FLOOR     = 26,
  parameter int HOT_LIMIT = 90,
  parameter int WINDOW    = 16,
  parameter int NBR       = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBR-1:0]   nbr_grant,
  input  logic             local_accept,
  output logic [EST_W-1:0] est_temp,
  output logic             over_limit
);
  localparam int CW    = (WINDOW > 1) ? $clog2(WINDOW) : 1;
  localparam int SW    = EST_W + 8;
  localparam int MAXV  = (1 << EST_W) - 1;

  logic [CW-1:0] idle_cnt;
  logic [3:0]    n_evt;
  logic [SW-1:0] raised, lowered;
  logic          active, expire;

  always_comb begin
    n_evt = {3'b0, local_accept};
    for (int i = 0; i < NBR; i++) n_evt = n_evt + {3'b0, nbr_grant[i]};
  end

  assign active  = (n_evt != 4'd0);
  assign expire  = !active && (idle_cnt == CW'(WINDOW - 1));
  assign raised  = SW'(est_temp) + SW'(n_evt) * SW'(STEP_UP);
  assign lowered = (SW'(est_temp) >= SW'(FLOOR + COOL_STEP)) ?
                   SW'(est_temp) - SW'(COOL_STEP) : SW'(FLOOR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      est_temp   <= EST_W'(FLOOR);
      idle_cnt   <= '0;
      over_limit <= 1'b0;
    end else begin
      over_limit <= (est_temp > EST_W'(HOT_LIMIT));
      if (active) begin
        idle_cnt <= '0;
        est_temp <= (raised > SW'(MAXV)) ? EST_W'(MAXV) : raised[EST_W-1:0];
      end else if (expire) begin
        idle_cnt <= '0;
        est_temp <= lowered[EST_W-1:0];
      end else begin
        idle_cnt <= idle_cnt + 1'b1;
      end
    end
  end
endmodule

module thermal_load_estimator_chk #(
  parameter int EST_W     = 8,
  parameter int STEP_UP   = 4,
  parameter int COOL_STEP = 2,
  parameter int FLOOR     = 26,
  parameter int HOT_LIMIT = 90,
  parameter int NBR       = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NBR-1:0]   nbr_grant,
  input logic             local_accept,
  input logic [EST_W-1:0] est_temp,
  input logic             over_limit
);
  localparam int MAXV = (1 << EST_W) - 1;

  AST_ABOVE_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    est_temp >= EST_W'(FLOOR)); // R6
  AST_GROWS_ON_WORK: assert property (@(posedge clk) disable iff (!rst_n)
    ((|nbr_grant) || local_accept) && (est_temp < EST_W'(MAXV)) |=> est_temp > $past(est_temp)); // R2
  AST_RISE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ((|nbr_grant) || local_accept) |=> (int'(est_temp) - int'($past(est_temp)) <= (NBR + 1) * STEP_UP)); // R2
  AST_NO_RISE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (nbr_grant == '0) && !local_accept |=> est_temp <= $past(est_temp)); // R4
  AST_COOL_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    (est_temp < $past(est_temp)) |-> (int'($past(est_temp)) - int'(est_temp) <= COOL_STEP)); // R5
  AST_FLAG_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(over_limit) |-> $past(est_temp) > EST_W'(HOT_LIMIT)); // R7
  AST_FLAG_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $past(est_temp) <= EST_W'(HOT_LIMIT) |-> !over_limit); // R7
endmodule

bind thermal_load_estimator thermal_load_estimator_chk #(
  .EST_W(EST_W), .STEP_UP(STEP_UP), .COOL_STEP(COOL_STEP),
  .FLOOR(FLOOR), .HOT_LIMIT(HOT_LIMIT), .NBR(NBR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .nbr_grant(nbr_grant),
  .local_accept(local_accept), .est_temp(est_temp), .over_limit(over_limit)
);

// File: tb/thermal_load_estimator_test.sv
module thermal_load_estimator_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] nbr_grant = 4'b0;
  logic       local_accept = 1'b0;
  logic [7:0] est_temp;
  logic       over_limit;

  int checks = 0;
  int fails = 0;
  int m_est = 26;
  int m_idle = 0;
  int m_flag = 0;

  always #5 clk = ~clk;

  thermal_load_estimator uut (
    .clk(clk), .rst_n(rst_n), .nbr_grant(nbr_grant),
    .local_accept(local_accept), .est_temp(est_temp), .over_limit(over_limit)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] g, input logic a);
    int n;
    int nf;
    nbr_grant = g;
    local_accept = a;
    n = $countones(g) + int'(a);
    nf = (m_est > 90) ? 1 : 0;
    if (n != 0) begin
      m_est = m_est + 4 * n;
      if (m_est > 255) m_est = 255;
      m_idle = 0;
    end else if (m_idle == 15) begin
      m_est = (m_est - 2 < 26) ? 26 : m_est - 2;
      m_idle = 0;
    end else begin
      m_idle++;
    end
    m_flag = nf;
    @(posedge clk);
    @(negedge clk);
    nbr_grant = 4'b0;
    local_accept = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 est in reset", int'(est_temp), 26);
    check("R1 flag in reset", int'(over_limit), 0);
    @(negedge clk);
    rst_n = 1'b1;
    m_est = 26; m_idle = 0; m_flag = 0;
  endtask

  task automatic test_single_sources();
    do_reset();
    for (int i = 0; i < 4; i++) begin
      step(4'(1 << i), 1'b0);
      check("R2 single grant", int'(est_temp), m_est);
    end
    step(4'b0, 1'b1);
    check("R2 local accept", int'(est_temp), 26 + 20);
  endtask

  task automatic test_multi();
    do_reset();
    step(4'b1111, 1'b1);
    check("R2 five at once", int'(est_temp), 46);
    step(4'b0101, 1'b0);
    check("R2 two grants", int'(est_temp), 54);
  endtask

  task automatic test_saturate();
    do_reset();
    for (int i = 0; i < 12; i++) step(4'b1111, 1'b1);
    check("R3 saturate", int'(est_temp), 255);
    step(4'b1111, 1'b1);
    check("R3 hold at max", int'(est_temp), 255);
    check("R7 flag high", int'(over_limit), 1);
  endtask

  task automatic test_cooling();
    do_reset();
    step(4'b0, 1'b1);
    for (int i = 0; i < 15; i++) step(4'b0, 1'b0);
    check("R5 hold before expiry", int'(est_temp), 30);
    step(4'b0, 1'b0);
    check("R5 cool on expiry", int'(est_temp), 28);
    for (int i = 0; i < 10; i++) step(4'b0, 1'b0);
    step(4'b0010, 1'b0);
    check("R4 event adds", int'(est_temp), 32);
    for (int i = 0; i < 15; i++) step(4'b0, 1'b0);
    check("R4 window restarted", int'(est_temp), 32);
    step(4'b0, 1'b0);
    check("R4 cool after full window", int'(est_temp), 30);
    check("R5 model agrees", int'(est_temp), m_est);
  endtask

  task automatic test_floor();
    do_reset();
    for (int i = 0; i < 40; i++) step(4'b0, 1'b0);
    check("R6 stays at floor", int'(est_temp), 26);
    step(4'b0, 1'b1);
    for (int i = 0; i < 48; i++) step(4'b0, 1'b0);
    check("R6 floor after cooling", int'(est_temp), 26);
  endtask

  task automatic test_threshold();
    do_reset();
    for (int i = 0; i < 16; i++) step(4'b0, 1'b1);
    check("R7 est at 90", int'(est_temp), 90);
    step(4'b0, 1'b0);
    check("R7 flag low at 90", int'(over_limit), 0);
    step(4'b1000, 1'b0);
    check("R7 est 94", int'(est_temp), 94);
    check("R7 flag still lagging", int'(over_limit), 0);
    step(4'b0, 1'b0);
    check("R7 flag one cycle later", int'(over_limit), 1);
    check("R7 model flag", int'(over_limit), m_flag);
  endtask

  initial begin
    test_single_sources();
    test_multi();
    test_saturate();
    test_cooling();
    test_floor();
    test_threshold();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule